// File: doc/BRIEF.md
# Vertical Sync Detector

This block monitors a sampled, active-low composite sync bit and finds the start of each vertical interval. It times every low pulse in clock cycles and sorts it into one of three classes: equalizing (narrow), horizontal (normal line sync) or serration (broad). When the first broad pulse of a field ends, the block drives an active-low vertical sync pulse of fixed length.

A fallback timer covers sources that omit the broad pulses. The timer is restarted by every equalizing pulse. If no broad pulse arrives, the timer forces the vertical sync pulse about 60 µs after the last equalizing falling edge. A flag output reports which path produced the current pulse. Once a pulse ends, the block ignores equalizing and broad pulses until it sees one horizontal-width pulse, so that one field gives one vertical pulse.

All time limits are given in microseconds and converted to clock counts from a nominal clock frequency parameter. The composite sync input passes through one register before any edge or width logic sees it.

Top module: `vsync_detector`

## Requirements
- R1: While reset is asserted and after it is released, `vsync_n_o` is 1 and `vsync_forced_o` is 0. The detector then waits idle with the fallback timer disarmed.
- R2: A low pulse is classed when it ends, by its length L in clock cycles. L < EQ_MAX_CYC (4 µs) makes it equalizing. L >= SERR_MIN_CYC (16 µs) makes it a serration pulse. Any L between the two makes it a horizontal pulse.
- R3: Each equalizing pulse seen while idle restarts the fallback timer from that pulse's falling edge. A horizontal pulse neither restarts nor stops the timer.
- R4: While idle, the rising edge that ends a serration pulse drives `vsync_n_o` low on the second clock edge after the input rises, with `vsync_forced_o` = 0.
- R5: If the timer is armed and no serration pulse ends first, `vsync_n_o` goes low within 4 cycles of TIMEOUT_CYC (60 µs) after the last equalizing falling edge, with `vsync_forced_o` = 1.
- R6: Once `vsync_n_o` goes low, it stays low for exactly HOLD_CYC cycles (190 µs), whatever the input does during that time.
- R7: After the vertical pulse ends, equalizing and serration pulses have no effect. The first horizontal pulse returns the detector to idle, and the next serration pulse triggers again.
- R8: `vsync_forced_o` does not change while `vsync_n_o` is low.
- R9: Asserting `rst_n` in the middle of a vertical pulse drives `vsync_n_o` high and `vsync_forced_o` low at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csync_n_i | input | 1 | Sliced composite sync, low during sync pulses |
| vsync_n_o | output | 1 | Vertical sync, active low |
| vsync_forced_o | output | 1 | 1 = pulse forced by the timeout, 0 = pulse triggered by a serration pulse; valid while `vsync_n_o` is low |

## Verification
A wrong width count or a wrong class boundary shows as a missing or extra vertical pulse within about three cycles of the pulse's rising edge. The boundary widths of 15, 16, 63 and 64 cycles are chosen to expose this. A timer that does not restart, or that restarts on the wrong pulse, moves the forced pulse by roughly half a line, so a ±4-cycle window around 60 µs detects it. A fault in the hold counter or in the state that blocks retriggering shows as a pulse that ends at the wrong cycle, or as a second pulse in the same field, within one field time.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HOLD   = 2'd1,
    ST_WAIT_H = 2'd2
  } vsd_state_e;
endpackage

// File: rtl/vsd_width_meter.sv
module vsd_width_meter #(
  parameter int EQ_MAX_CYC   = 16,
  parameter int SERR_MIN_CYC = 64,
  parameter int WW           = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csync_n_i,
  output logic          eq_rise_o,
  output logic          h_rise_o,
  output logic          serr_rise_o,
  output logic [WW-1:0] width_o
);
  localparam logic [WW-1:0] EQ_LIM  = WW'(EQ_MAX_CYC);
  localparam logic [WW-1:0] SAT_LIM = WW'(SERR_MIN_CYC);

  logic          s0_q, s1_q, rise;
  logic [WW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b1;
      s1_q <= 1'b1;
    end else begin
      s0_q <= csync_n_i;
      s1_q <= s0_q;
    end
  end

  assign rise = s0_q & ~s1_q;

  // low-time counter, saturating at the broad-pulse limit
  always_comb begin
    cnt_en = !s0_q || (cnt_q != '0);
    cnt_d  = '0;
    if (!s0_q) cnt_d = (cnt_q == SAT_LIM) ? cnt_q : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign width_o     = cnt_q;
  assign eq_rise_o   = rise && (cnt_q < EQ_LIM);
  assign serr_rise_o = rise && (cnt_q >= SAT_LIM);
  assign h_rise_o    = rise && (cnt_q >= EQ_LIM) && (cnt_q < SAT_LIM);

  a_r2_width_capped: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SAT_LIM);
  a_r2_rise_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (cnt_q == '0));
endmodule

// File: rtl/vsd_fallback_timer.sv
module vsd_fallback_timer #(
  parameter int TIMEOUT_CYC = 240,
  parameter int TW          = 8,
  parameter int WW          = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle_i,
  input  logic          eq_rise_i,
  input  logic [WW-1:0] width_i,
  output logic          fire_o
);
  localparam logic [TW-1:0] T_LIM = TW'(TIMEOUT_CYC - 1);

  logic          armed_q, armed_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmr_en;

  always_comb begin
    armed_d = armed_q;
    tmr_d   = tmr_q;
    tmr_en  = 1'b1;
    if (!idle_i) begin
      armed_d = 1'b0;
      tmr_d   = '0;
    end else if (eq_rise_i) begin
      // time already elapsed since the falling edge is the pulse width
      armed_d = 1'b1;
      tmr_d   = TW'(width_i);
    end else if (armed_q && tmr_q != T_LIM) begin
      tmr_d = tmr_q + 1'b1;
    end else begin
      tmr_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      tmr_q   <= '0;
    end else if (tmr_en) begin
      armed_q <= armed_d;
      tmr_q   <= tmr_d;
    end
  end

  assign fire_o = armed_q && (tmr_q >= T_LIM);

  a_r3_eq_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && eq_rise_i) |=> armed_q);
  a_r5_disarm_outside_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_i |=> !armed_q);
endmodule

// File: rtl/vsd_vs_ctrl.sv
module vsd_vs_ctrl
  import vsd_pkg::*;
#(
  parameter int HOLD_CYC = 760,
  parameter int HW       = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic serr_rise_i,
  input  logic h_rise_i,
  input  logic fire_i,
  output logic idle_o,
  output logic vsync_n_o,
  output logic forced_o
);
  localparam logic [HW-1:0] H_LIM = HW'(HOLD_CYC - 1);

  vsd_state_e    state_q, state_d;
  logic [HW-1:0] hold_q, hold_d;
  logic          src_q, src_d;
  logic          vs_n_q;

  always_comb begin
    state_d = state_q;
    hold_d  = hold_q;
    src_d   = src_q;
    case (state_q)
      ST_IDLE: begin
        hold_d = '0;
        if (serr_rise_i) begin
          state_d = ST_HOLD;
          src_d   = 1'b0;
        end else if (fire_i) begin
          state_d = ST_HOLD;
          src_d   = 1'b1;
        end
      end
      ST_HOLD: begin
        if (hold_q == H_LIM) begin
          state_d = ST_WAIT_H;
          hold_d  = '0;
        end else begin
          hold_d = hold_q + 1'b1;
        end
      end
      ST_WAIT_H: if (h_rise_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
      src_q   <= 1'b0;
      vs_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      src_q   <= src_d;
      vs_n_q  <= (state_d != ST_HOLD);
    end
  end

  assign idle_o    = (state_q == ST_IDLE);
  assign vsync_n_o = vs_n_q;
  assign forced_o  = src_q;

  a_r4_serration_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && serr_rise_i) |=> (!vsync_n_o && !forced_o));
  a_r5_timeout_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && fire_i && !serr_rise_i) |=> (!vsync_n_o && forced_o));
  a_r6_hold_full_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_n_o) |-> ($past(hold_q) == H_LIM));
  a_r7_blocked_until_h: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_H) |=> vsync_n_o);
  a_r8_flag_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!vsync_n_o && $past(!vsync_n_o)) |-> $stable(forced_o));
endmodule

// File: rtl/vsync_detector.sv
module vsync_detector #(
  parameter int CLK_KHZ     = 27000,
  parameter int EQ_MAX_US   = 4,
  parameter int SERR_MIN_US = 16,
  parameter int TIMEOUT_US  = 60,
  parameter int HOLD_US     = 190
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_n_i,
  output logic vsync_n_o,
  output logic vsync_forced_o
);
  localparam int EQ_MAX_CYC   = CLK_KHZ * EQ_MAX_US / 1000;
  localparam int SERR_MIN_CYC = CLK_KHZ * SERR_MIN_US / 1000;
  localparam int TIMEOUT_CYC  = CLK_KHZ * TIMEOUT_US / 1000;
  localparam int HOLD_CYC     = CLK_KHZ * HOLD_US / 1000;
  localparam int WW = $clog2(SERR_MIN_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic          rst_meta_q, rst_sync_q;
  logic          eq_rise, h_rise, serr_rise, fire, idle;
  logic [WW-1:0] width;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  vsd_width_meter #(
    .EQ_MAX_CYC(EQ_MAX_CYC), .SERR_MIN_CYC(SERR_MIN_CYC), .WW(WW)
  ) u_meter (
    .clk(clk), .rst_n(rst_sync_q), .csync_n_i(csync_n_i),
    .eq_rise_o(eq_rise), .h_rise_o(h_rise), .serr_rise_o(serr_rise),
    .width_o(width)
  );

  vsd_fallback_timer #(
    .TIMEOUT_CYC(TIMEOUT_CYC), .TW(TW), .WW(WW)
  ) u_timer (
    .clk(clk), .rst_n(rst_sync_q), .idle_i(idle), .eq_rise_i(eq_rise),
    .width_i(width), .fire_o(fire)
  );

  vsd_vs_ctrl #(
    .HOLD_CYC(HOLD_CYC), .HW(HW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync_q), .serr_rise_i(serr_rise), .h_rise_i(h_rise),
    .fire_i(fire), .idle_o(idle), .vsync_n_o(vsync_n_o),
    .forced_o(vsync_forced_o)
  );
endmodule

// File: tb/vsync_detector_test.sv
module vsync_detector_test;
  // 4 clocks per microsecond: EQ 16, SERR 64, TIMEOUT 240, HOLD 760 cycles
  logic clk = 1'b0;
  logic rst_n;
  logic csync_n;
  logic vs_n, vs_forced;
  int   checks = 0;
  int   errors = 0;

  always #2 clk = ~clk;

  vsync_detector #(.CLK_KHZ(4000)) uut (
    .clk(clk), .rst_n(rst_n), .csync_n_i(csync_n),
    .vsync_n_o(vs_n), .vsync_forced_o(vs_forced)
  );

  // rows: low cycles, high cycles, expected vsync_n, expected flag (2 = don't care)
  localparam int NV = 24;
  localparam int VEC [NV][4] = '{
    '{19, 237, 1, 2}, '{19, 237, 1, 2},
    '{9, 119, 1, 2}, '{9, 119, 1, 2}, '{9, 119, 1, 2},
    '{9, 119, 1, 2}, '{9, 119, 1, 2}, '{9, 119, 1, 2},
    '{100, 28, 0, 0}, '{100, 28, 0, 0}, '{100, 28, 0, 0},
    '{100, 28, 0, 0}, '{100, 28, 0, 0}, '{100, 28, 0, 0},
    '{9, 119, 1, 2}, '{9, 119, 1, 2}, '{9, 119, 1, 2},
    '{9, 119, 1, 2}, '{9, 119, 1, 2}, '{9, 119, 1, 2},
    '{19, 237, 1, 2}, '{19, 237, 1, 2}, '{19, 237, 1, 2},
    '{19, 237, 1, 2}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic level(input logic v, input int n);
    csync_n = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    csync_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    csync_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 vsync in reset", vs_n, 1);
    check("R1 flag in reset", vs_forced, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 vsync after reset", vs_n, 1);
    check("R1 flag after reset", vs_forced, 0);

    // full field with serration phase (R4 R6 R7)
    for (int i = 0; i < NV; i++) begin
      level(1'b0, VEC[i][0]);
      level(1'b1, VEC[i][1]);
      check($sformatf("R4 R6 R7 table row %0d vsync", i), vs_n, VEC[i][2]);
      if (VEC[i][3] != 2)
        check($sformatf("R4 table row %0d flag", i), vs_forced, VEC[i][3]);
    end

    // exact trigger cycle and hold length
    level(1'b0, 100);
    level(1'b1, 1);
    check("R4 vsync one edge after rise", vs_n, 1);
    level(1'b1, 1);
    check("R4 vsync two edges after rise", vs_n, 0);
    check("R4 serration flag", vs_forced, 0);
    level(1'b1, 758);
    check("R6 vsync still low near end", vs_n, 0);
    level(1'b1, 3);
    check("R6 vsync released after hold", vs_n, 1);

    // blocked until a horizontal pulse
    level(1'b0, 100);
    level(1'b1, 28);
    check("R7 serration ignored before h pulse", vs_n, 1);
    level(1'b0, 9);
    level(1'b1, 300);
    check("R7 equalizing ignored before h pulse", vs_n, 1);
    level(1'b0, 19);
    level(1'b1, 40);
    level(1'b0, 100);
    level(1'b1, 28);
    check("R7 serration retriggers after h pulse", vs_n, 0);
    level(1'b1, 800);

    // timeout restarted by second equalizing pulse
    do_reset();
    level(1'b0, 9);
    level(1'b1, 119);
    level(1'b0, 9);
    level(1'b1, 228);
    check("R3 restart: no vsync at 236 after last fall", vs_n, 1);
    level(1'b1, 8);
    check("R5 forced vsync near 240", vs_n, 0);
    check("R5 forced flag", vs_forced, 1);
    level(1'b1, 300);
    check("R8 flag held during forced pulse", vs_forced, 1);
    check("R6 forced pulse still low", vs_n, 0);

    // horizontal pulse does not restart the timer
    do_reset();
    level(1'b0, 9);
    level(1'b1, 100);
    level(1'b0, 19);
    level(1'b1, 109);
    check("R3 h pulse no restart, before timeout", vs_n, 1);
    level(1'b1, 8);
    check("R3 h pulse no restart, timeout taken", vs_n, 0);

    // width boundaries
    do_reset();
    level(1'b0, 15);
    level(1'b1, 260);
    check("R2 width 15 is equalizing", vs_n, 0);
    do_reset();
    level(1'b0, 16);
    level(1'b1, 300);
    check("R2 width 16 is horizontal", vs_n, 1);
    level(1'b0, 63);
    level(1'b1, 5);
    check("R2 width 63 not serration", vs_n, 1);
    do_reset();
    level(1'b0, 64);
    level(1'b1, 3);
    check("R2 width 64 is serration", vs_n, 0);
    check("R2 width 64 flag", vs_forced, 0);

    // asynchronous reset mid-pulse
    level(1'b1, 50);
    rst_n = 1'b0;
    #1;
    check("R9 vsync after async reset", vs_n, 1);
    check("R9 flag after async reset", vs_forced, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 idle after second reset", vs_n, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule